// File: doc/BRIEF.md
# Transmit Mailbox Priority Scheduler

This block decides which of three transmit mailboxes goes to the bus engine next. Software loads a mailbox by pulsing its request line with an identifier. The mailbox then stays pending until its request ends, either through a successful transmission or through a failure that is not retried. One mode input picks the order. In identifier mode the lowest identifier wins. In queue mode the oldest request wins. A second mode input turns off automatic retransmission after a failed attempt.

The scheduler waits for the bus engine to report idle. It then issues a one-cycle start strobe together with the chosen mailbox index and marks that mailbox as in flight. The bus engine reports the end of the attempt as success, lost arbitration or error. A success releases the mailbox and sets its success bit. A failure either keeps the mailbox pending for another attempt, or releases it and sets its failure bit, depending on the retransmission mode. Request order is kept as a small rank per mailbox: rank 0 is the oldest pending request.

Top module: `tx_mbox_sched`

## Requirements
- R1: After reset no mailbox is pending, start_o is low and every success and failure bit is clear.
- R2: A request pulse on a mailbox that is not pending makes it pending with the given identifier. A request pulse on a mailbox that is already pending is ignored: its identifier and queue position stay as they were.
- R3: With fifo_mode_i low, the pending mailbox with the numerically lowest identifier is started first.
- R4: With fifo_mode_i low, equal identifiers are resolved in favour of the lower mailbox index.
- R5: With fifo_mode_i high, pending mailboxes are started in the order their requests were accepted. Requests accepted in the same cycle are ordered by mailbox index, lower first.
- R6: A start is issued only when eng_idle_i is high and no attempt is in flight. It is a single-cycle start_o pulse, with sel_idx_o (binary index 0..2) naming a pending mailbox. The pulse appears one clock edge after a pending mailbox and idle are seen.
- R7: tx_ok_i during an attempt clears that mailbox's pending bit and sets its done_ok_o bit.
- R8: With no_retx_i low, arb_lost_i or tx_err_i during an attempt leaves the mailbox pending, without a failure bit, and it competes again for the next start.
- R9: With no_retx_i high, arb_lost_i or tx_err_i during an attempt clears the mailbox's pending bit and sets its done_fail_o bit.
- R10: An accepted request clears both status bits of that mailbox.
- R11: Completion inputs have no effect while no attempt is in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fifo_mode_i | input | 1 | 1: request order, 0: lowest identifier first |
| no_retx_i | input | 1 | 1: a failed attempt ends the request |
| req_i | input | N_MBOX | Per-mailbox request pulse |
| req_id_i | input | N_MBOX*ID_W | Identifiers; mailbox i uses bits [i*ID_W +: ID_W] |
| eng_idle_i | input | 1 | Bus engine is ready for a new frame |
| tx_ok_i | input | 1 | Attempt completed successfully |
| arb_lost_i | input | 1 | Attempt lost arbitration |
| tx_err_i | input | 1 | Attempt ended with an error |
| start_o | output | 1 | One-cycle start strobe |
| sel_idx_o | output | IDX_W | Index of the started mailbox |
| pend_o | output | N_MBOX | Pending bit per mailbox |
| done_ok_o | output | N_MBOX | Success status per mailbox |
| done_fail_o | output | N_MBOX | Failure status per mailbox |

## Verification
Each request becomes visible on pend_o one edge after it is sampled. The earliest start for it comes one edge later still. A completion input changes pend_o, done_ok_o and done_fail_o at the next edge, and the next start can follow no sooner than one edge after that. A behavioural reference model steps on the same edge as the design, and every output is compared half a cycle later, away from the edge. Directed checks poll for the strobe at falling edges and sample status at the falling edge right after the completion pulse has been taken.

// File: rtl/tx_sched_pkg.sv
package tx_sched_pkg;
  typedef enum logic [1:0] {
    EV_NONE = 2'd0,
    EV_OK   = 2'd1,
    EV_FAIL = 2'd2
  } tx_ev_e;
endpackage

// File: rtl/tx_mbox_slot.sv
module tx_mbox_slot #(
  parameter int ID_W   = 11,
  parameter int RANK_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [ID_W-1:0]   id_i,
  input  logic [RANK_W-1:0] rank_i,
  input  logic              drop_i,
  input  logic              shift_i,
  input  logic              ok_i,
  input  logic              fail_i,
  output logic              pend_o,
  output logic [ID_W-1:0]   id_o,
  output logic [RANK_W-1:0] rank_o,
  output logic              ok_o,
  output logic              fail_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_o <= 1'b0;
      id_o   <= '0;
      rank_o <= '0;
      ok_o   <= 1'b0;
      fail_o <= 1'b0;
    end else if (load_i) begin
      pend_o <= 1'b1;
      id_o   <= id_i;
      rank_o <= rank_i;
      ok_o   <= 1'b0;
      fail_o <= 1'b0;
    end else begin
      if (drop_i)  pend_o <= 1'b0;
      if (shift_i) rank_o <= rank_o - RANK_W'(1);
      if (ok_i)    ok_o   <= 1'b1;
      if (fail_i)  fail_o <= 1'b1;
    end
  end
endmodule

// File: rtl/tx_prio_pick.sv
module tx_prio_pick #(
  parameter int N_MBOX = 3,
  parameter int ID_W   = 11,
  parameter int RANK_W = 2,
  parameter int IDX_W  = 2
) (
  input  logic                     fifo_mode_i,
  input  logic [N_MBOX-1:0]        pend_i,
  input  logic [N_MBOX*ID_W-1:0]   id_i,
  input  logic [N_MBOX*RANK_W-1:0] rank_i,
  output logic [IDX_W-1:0]         win_o
);
  logic            found;
  logic [ID_W-1:0] best_id;

  always_comb begin
    found   = 1'b0;
    best_id = '0;
    win_o   = '0;
    for (int i = 0; i < N_MBOX; i++) begin
      if (pend_i[i]) begin
        if (fifo_mode_i) begin
          if (rank_i[i*RANK_W +: RANK_W] == '0) win_o = IDX_W'(i);
        end else if (!found || id_i[i*ID_W +: ID_W] < best_id) begin
          // strict less-than keeps the lower index on a tie
          found   = 1'b1;
          best_id = id_i[i*ID_W +: ID_W];
          win_o   = IDX_W'(i);
        end
      end
    end
  end
endmodule

// File: rtl/tx_mbox_sched.sv
module tx_mbox_sched
  import tx_sched_pkg::*;
#(
  parameter int N_MBOX = 3,
  parameter int ID_W   = 11,
  localparam int IDX_W = (N_MBOX > 1) ? $clog2(N_MBOX) : 1
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   fifo_mode_i,
  input  logic                   no_retx_i,
  input  logic [N_MBOX-1:0]      req_i,
  input  logic [N_MBOX*ID_W-1:0] req_id_i,
  input  logic                   eng_idle_i,
  input  logic                   tx_ok_i,
  input  logic                   arb_lost_i,
  input  logic                   tx_err_i,
  output logic                   start_o,
  output logic [IDX_W-1:0]       sel_idx_o,
  output logic [N_MBOX-1:0]      pend_o,
  output logic [N_MBOX-1:0]      done_ok_o,
  output logic [N_MBOX-1:0]      done_fail_o
);
  localparam int RANK_W = IDX_W;

  logic                     busy_q;
  tx_ev_e                   ev;
  logic                     grant;
  logic [IDX_W-1:0]         win;
  logic [N_MBOX-1:0]        load, rel, shift, mark_ok, mark_fail;
  logic [RANK_W-1:0]        rel_rank;
  logic [N_MBOX*RANK_W-1:0] load_rank, rank_flat;
  logic [N_MBOX*ID_W-1:0]   id_flat;
  int unsigned              base_cnt, lower_cnt;

  always_comb begin
    ev = EV_NONE;
    if (busy_q) begin
      if (tx_ok_i)                  ev = EV_OK;
      else if (arb_lost_i || tx_err_i) ev = EV_FAIL;
    end
  end

  assign grant = !busy_q && eng_idle_i && (|pend_o);

  always_comb begin
    rel_rank = '0;
    for (int i = 0; i < N_MBOX; i++) begin
      rel[i] = busy_q && (sel_idx_o == IDX_W'(i)) &&
               (ev == EV_OK || (ev == EV_FAIL && no_retx_i));
      mark_ok[i]   = rel[i] && (ev == EV_OK);
      mark_fail[i] = rel[i] && (ev == EV_FAIL);
      if (rel[i]) rel_rank = rank_flat[i*RANK_W +: RANK_W];
    end
    for (int i = 0; i < N_MBOX; i++)
      shift[i] = (|rel) && pend_o[i] && !rel[i] &&
                 (rank_flat[i*RANK_W +: RANK_W] > rel_rank);
  end

  // a new request queues behind every mailbox still pending after this edge
  always_comb begin
    base_cnt  = 0;
    lower_cnt = 0;
    for (int i = 0; i < N_MBOX; i++)
      if (pend_o[i] && !rel[i]) base_cnt++;
    for (int i = 0; i < N_MBOX; i++) begin
      load[i] = req_i[i] && !pend_o[i];
      load_rank[i*RANK_W +: RANK_W] = RANK_W'(base_cnt + lower_cnt);
      if (load[i]) lower_cnt++;
    end
  end

  for (genvar g = 0; g < N_MBOX; g++) begin : g_slot
    tx_mbox_slot #(.ID_W(ID_W), .RANK_W(RANK_W)) u_slot (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .load_i (load[g]),
      .id_i   (req_id_i[g*ID_W +: ID_W]),
      .rank_i (load_rank[g*RANK_W +: RANK_W]),
      .drop_i (rel[g]),
      .shift_i(shift[g]),
      .ok_i   (mark_ok[g]),
      .fail_i (mark_fail[g]),
      .pend_o (pend_o[g]),
      .id_o   (id_flat[g*ID_W +: ID_W]),
      .rank_o (rank_flat[g*RANK_W +: RANK_W]),
      .ok_o   (done_ok_o[g]),
      .fail_o (done_fail_o[g])
    );
  end

  tx_prio_pick #(.N_MBOX(N_MBOX), .ID_W(ID_W), .RANK_W(RANK_W), .IDX_W(IDX_W)) u_pick (
    .fifo_mode_i(fifo_mode_i),
    .pend_i     (pend_o),
    .id_i       (id_flat),
    .rank_i     (rank_flat),
    .win_o      (win)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q    <= 1'b0;
      start_o   <= 1'b0;
      sel_idx_o <= '0;
    end else begin
      start_o <= grant;
      if (grant) begin
        busy_q    <= 1'b1;
        sel_idx_o <= win;
      end else if (ev != EV_NONE) begin
        busy_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/tx_mbox_sched_chk.sv
module tx_mbox_sched_chk #(
  parameter int N_MBOX = 3,
  parameter int IDX_W  = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              no_retx_i,
  input logic              eng_idle_i,
  input logic              start_o,
  input logic [IDX_W-1:0]  sel_idx_o,
  input logic [N_MBOX-1:0] pend_o,
  input logic [N_MBOX-1:0] done_ok_o,
  input logic [N_MBOX-1:0] done_fail_o
);
  assert_start_pending_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |-> ((pend_o >> sel_idx_o) & N_MBOX'(1)) != '0);

  assert_start_idle_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |-> $past(eng_idle_i));

  assert_start_pulse_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |=> !start_o);

  assert_sel_range_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(sel_idx_o) < N_MBOX);

  assert_status_excl_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_ok_o & done_fail_o) == '0);

  assert_fail_noretx_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(done_fail_o & ~$past(done_fail_o))) |-> $past(no_retx_i));
endmodule

bind tx_mbox_sched tx_mbox_sched_chk #(.N_MBOX(N_MBOX), .IDX_W(IDX_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .no_retx_i  (no_retx_i),
  .eng_idle_i (eng_idle_i),
  .start_o    (start_o),
  .sel_idx_o  (sel_idx_o),
  .pend_o     (pend_o),
  .done_ok_o  (done_ok_o),
  .done_fail_o(done_fail_o)
);

// File: tb/tx_mbox_sched_test.sv
module tx_mbox_sched_test;
  localparam int N = 3;
  localparam int W = 11;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic fifo = 1'b0, noretx = 1'b0, idle = 1'b0;
  logic okp = 1'b0, arb = 1'b0, err = 1'b0;
  logic [N-1:0] req = '0;
  logic [N*W-1:0] ids = '0;
  logic start;
  logic [1:0] sel;
  logic [N-1:0] pend, dok, dfail;

  int n_chk = 0, n_fail = 0, cyc = 0;
  string phase = "R1";

  always #5 clk = ~clk;

  tx_mbox_sched #(.N_MBOX(N), .ID_W(W)) uut (
    .clk_i(clk), .rst_ni(rst_n), .fifo_mode_i(fifo), .no_retx_i(noretx),
    .req_i(req), .req_id_i(ids), .eng_idle_i(idle), .tx_ok_i(okp),
    .arb_lost_i(arb), .tx_err_i(err), .start_o(start), .sel_idx_o(sel),
    .pend_o(pend), .done_ok_o(dok), .done_fail_o(dfail));

  task automatic chk(input bit good, input string rq, input int act, input int exp);
    n_chk++;
    if (!good) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  // reference model
  bit [N-1:0] m_pend, m_ok, m_fail, oldp;
  int m_id[N];
  int q[$];
  bit m_busy, m_start;
  int m_sel, w;

  function automatic void m_release(bit good);
    m_pend[m_sel] = 1'b0;
    if (good) m_ok[m_sel] = 1'b1; else m_fail[m_sel] = 1'b1;
    foreach (q[k]) if (q[k] == m_sel) begin q.delete(k); break; end
    m_busy = 1'b0;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_pend = '0; m_ok = '0; m_fail = '0; q.delete();
      m_busy = 0; m_start = 0; m_sel = 0;
    end else begin
      oldp = m_pend;
      m_start = 0;
      if (m_busy) begin
        if (okp) m_release(1);
        else if (arb || err) begin
          if (noretx) m_release(0); else m_busy = 0;
        end
      end else if (idle && oldp != 0) begin
        if (fifo) w = q[0];
        else begin
          w = -1;
          for (int i = 0; i < N; i++)
            if (oldp[i] && (w < 0 || m_id[i] < m_id[w])) w = i;
        end
        m_start = 1; m_sel = w; m_busy = 1;
      end
      for (int i = 0; i < N; i++)
        if (req[i] && !oldp[i]) begin
          m_pend[i] = 1; m_id[i] = int'(ids[i*W +: W]);
          m_ok[i] = 0; m_fail[i] = 0; q.push_back(i);
        end
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      chk(start == m_start, phase, start, m_start);
      if (m_start) chk(int'(sel) == m_sel, phase, sel, m_sel);
      chk(pend == m_pend, phase, pend, m_pend);
      chk(dok == m_ok, phase, dok, m_ok);
      chk(dfail == m_fail, phase, dfail, m_fail);
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=0", cyc);
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  task automatic pulse_req(input bit [N-1:0] m, input int i0, input int i1, input int i2);
    @(negedge clk);
    req = m;
    ids = {W'(i2), W'(i1), W'(i0)};
    @(negedge clk);
    req = '0;
  endtask

  task automatic expect_start(input int exp, input string rq);
    for (int n = 0; n < 20; n++) begin
      @(negedge clk);
      if (start) begin
        chk(int'(sel) == exp, rq, sel, exp);
        return;
      end
    end
    chk(0, rq, -1, exp);
  endtask

  // kind: 0 ok, 1 arbitration lost, 2 error
  task automatic finish_tx(input int kind);
    @(negedge clk);
    okp = (kind == 0); arb = (kind == 1); err = (kind == 2);
    @(negedge clk);
    okp = 0; arb = 0; err = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(pend == 0 && !start && dok == 0 && dfail == 0, "R1", {pend, dok, dfail}, 0);

    phase = "R6";
    pulse_req(3'b111, 30, 10, 20);
    repeat (3) begin
      @(negedge clk);
      chk(!start, "R6", start, 0);
    end
    phase = "R3";
    idle = 1;
    expect_start(1, "R3");
    finish_tx(0);
    chk(dok[1] && !pend[1], "R7", {dok[1], pend[1]}, 2);
    expect_start(2, "R3"); finish_tx(0);
    expect_start(0, "R3"); finish_tx(0);

    phase = "R4";
    pulse_req(3'b111, 5, 5, 5);
    expect_start(0, "R4"); finish_tx(0);
    expect_start(1, "R4"); finish_tx(0);
    expect_start(2, "R4"); finish_tx(0);

    phase = "R2";
    idle = 0;
    pulse_req(3'b011, 60, 50, 0);
    pulse_req(3'b101, 1, 0, 45);
    idle = 1;
    expect_start(2, "R2"); finish_tx(0);
    expect_start(1, "R2"); finish_tx(0);
    expect_start(0, "R2"); finish_tx(0);

    phase = "R5";
    fifo = 1; idle = 0;
    pulse_req(3'b100, 0, 0, 9);
    pulse_req(3'b001, 3, 0, 0);
    pulse_req(3'b010, 0, 1, 0);
    idle = 1;
    expect_start(2, "R5"); finish_tx(0);
    expect_start(0, "R5"); finish_tx(0);
    expect_start(1, "R5"); finish_tx(0);
    fifo = 0;

    phase = "R8";
    pulse_req(3'b010, 0, 7, 0);
    expect_start(1, "R8");
    finish_tx(1);
    chk(pend[1] && !dfail[1], "R8", {pend[1], dfail[1]}, 2);
    expect_start(1, "R8"); finish_tx(2);
    expect_start(1, "R8"); finish_tx(0);

    phase = "R9";
    noretx = 1;
    pulse_req(3'b001, 2, 0, 0);
    expect_start(0, "R9");
    finish_tx(2);
    chk(!pend[0] && dfail[0], "R9", {pend[0], dfail[0]}, 1);
    phase = "R10";
    idle = 0;
    pulse_req(3'b001, 4, 0, 0);
    chk(pend[0] && !dfail[0] && !dok[0], "R10", {pend[0], dfail[0], dok[0]}, 4);
    idle = 1;
    expect_start(0, "R10"); finish_tx(1);
    chk(dfail[0] && !pend[0], "R9", {dfail[0], pend[0]}, 2);
    noretx = 0;

    phase = "R11";
    finish_tx(0);
    finish_tx(1);
    chk(pend == 0 && dok == 3'b110 && dfail == 3'b001 && !start, "R11",
        {pend, dok, dfail}, {3'b000, 3'b110, 3'b001});
    repeat (3) @(negedge clk);

    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule